// File: doc/BRIEF.md
# Ethernet Status LED Driver with Blink Stretching

This block turns the single-cycle event strobes of an Ethernet transceiver (transmit, receive, collision) and its steady link and duplex status into four LED drive signals. Each event is too short to see, so the block holds it as a blink whose length is chosen by a 3-bit code. Codes 1 to 7 double the base period at each step, starting at 21 ms. Code 0 passes each event straight through. A free-running prescaler divides the clock into millisecond ticks and then into period strobes. An LED that sees an event stays lit until the second period strobe that follows, so a blink lasts between one and two base periods.

A 16-bit control word is loaded through a single-cycle write port. It holds a global disable bit, the stretch code and three mode bits. The mode bits choose what each LED shows. The transmit and receive LEDs can show bare activity, or a steady link light that blinks dark on activity. The duplex LED can show full duplex alone, or full duplex merged with stretched collisions. Any write to the control word restarts the prescaler, so a new code takes effect from a clean phase.

Top module: `led_stretch_ctrl`

## Requirements
- R1: After reset the control word is 0x2000: enabled (bit 15 = 0), stretch code 010 in bits 14:12, and mode bits 2:0 all 0. All LEDs are off while the inputs are idle. With this default, a lone transmit event gives a blink of one to two code-2 periods. Without a write, the stored word does not change.
- R2: While bit 15 of the control word is 1, all four LED outputs are 0 from the cycle after the word takes effect. This holds whatever the inputs are.
- R3: With code 000 (bits 14:12) there is no stretching. A one-cycle event gives a one-cycle LED pulse, one clock after the event.
- R4: With code c from 1 to 7, let P = 21·2^(c−1)·TICK_CYCLES clock cycles. A single one-cycle event, sent just after the control write, lights its LED for at least P and at most 2P+2 cycles.
- R5: An event that arrives while a blink is still lit re-arms the blink. Events spaced closer than P keep the LED lit with no dark cycle.
- R6: Bit 0 = 0: the transmit LED shows stretched transmit activity only, and receive events do not light it. Bit 0 = 1: the transmit LED is lit while the link is up and no stretched transmit or receive activity is present. It is dark while the link is down.
- R7: Bit 1 = 0: the receive LED shows stretched receive activity. Bit 1 = 1: the receive LED is lit while the link is up, dark for the stretched length of each receive event, and dark while the link is down.
- R8: Bit 2 = 0: the duplex LED is lit for full duplex or for a stretched collision. Bit 2 = 1: the duplex LED shows full duplex only, and collisions have no effect.
- R9: The link LED follows link_up with one clock of latency while enabled.
- R10: A stretch in progress loses one level on each period strobe and is reloaded to its full two-strobe length by each new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| ev_tx | input | 1 | Transmit activity event, one cycle |
| ev_rx | input | 1 | Receive activity event, one cycle |
| ev_col | input | 1 | Collision event, one cycle |
| link_up | input | 1 | Link status level |
| full_dup | input | 1 | Full-duplex status level |
| led_link | output | 1 | Link LED drive, active high |
| led_dup | output | 1 | Duplex/collision LED drive |
| led_rx | output | 1 | Receive LED drive |
| led_tx | output | 1 | Transmit LED drive |

## Verification
The state inside this block is the stretch level of each channel and the phase of the prescaler. An error in either shows at the ports as a blink of the wrong length. A level that is not reloaded shows as a dark gap within the first period after a repeated event. A decay that is missed or doubled shows at the end of the blink, as an on-time of about P too long or too short. A prescaler divided by the wrong amount shows as on-times that no longer double from code to code. All of these show within two periods of the event. A wrong control word shows within one clock as a lit LED under disable or a mode that does not match the written bit.

// File: rtl/led_pkg.sv
package led_pkg;

  typedef struct packed {
    logic       dis;
    logic [2:0] code;
    logic [8:0] rsvd;
    logic       dup_mode;
    logic       rx_mode;
    logic       tx_mode;
  } led_cfg_t;

  localparam logic [15:0] CFG_RESET = 16'h2000;

  // Base-period length in ms for a nonzero stretch code: base doubled per step.
  function automatic int unsigned period_ms(input logic [2:0] code, input int unsigned base);
    if (code == 3'd0) return base;
    return base << (code - 3'd1);
  endfunction

endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
  import led_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output led_cfg_t    cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= led_cfg_t'(CFG_RESET);
    else if (we) cfg <= led_cfg_t'(wdata);
  end
endmodule

// File: rtl/led_prescaler.sv
module led_prescaler
  import led_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 125000,
  parameter int unsigned BASE_MS     = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       ms_tick,
  output logic       stb
);
  localparam int unsigned MSW = $clog2(TICK_CYCLES + 1);
  localparam int unsigned PW  = $clog2(BASE_MS * 64 + 1);

  logic [MSW-1:0] ms_cnt;
  logic [PW-1:0]  per_cnt;
  logic           per_last;

  assign ms_tick  = (ms_cnt == MSW'(TICK_CYCLES - 1));
  assign per_last = (per_cnt == PW'(period_ms(code, BASE_MS) - 1));
  assign stb      = ms_tick && per_last;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ms_cnt  <= '0;
      per_cnt <= '0;
    end else begin
      ms_cnt <= ms_tick ? '0 : ms_cnt + 1'b1;
      if (ms_tick) per_cnt <= per_last ? '0 : per_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raw_mode,
  input  logic         stb,
  input  logic [N-1:0] ev,
  output logic [N-1:0] act,
  output logic [2*N-1:0] pend_flat
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [1:0] pend;
    always_ff @(posedge clk) begin
      if (!rst_n || raw_mode) pend <= 2'd0;
      else if (ev[i])         pend <= 2'd2;
      else if (stb && pend != 2'd0) pend <= pend - 2'd1;
    end
    assign act[i] = ev[i] || (pend != 2'd0);
    assign pend_flat[2*i +: 2] = pend;
  end
endmodule

// File: rtl/led_stretch_ctrl.sv
module led_stretch_ctrl
  import led_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 125000,
  parameter int unsigned BASE_MS     = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic        ev_tx,
  input  logic        ev_rx,
  input  logic        ev_col,
  input  logic        link_up,
  input  logic        full_dup,
  output logic        led_link,
  output logic        led_dup,
  output logic        led_rx,
  output logic        led_tx
);
  localparam int unsigned NCH = 3;

  led_cfg_t         cfg_q;
  logic             ms_tick, stb;
  logic [NCH-1:0]   ev_vec, act;
  logic [2*NCH-1:0] pend_flat;
  logic             tx_n, rx_n, dup_n;

  led_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg_q)
  );

  led_prescaler #(.TICK_CYCLES(TICK_CYCLES), .BASE_MS(BASE_MS)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .code(cfg_q.code),
    .ms_tick(ms_tick), .stb(stb)
  );

  assign ev_vec = {ev_col, ev_rx, ev_tx};

  led_pulse_stretch #(.N(NCH)) u_str (
    .clk(clk), .rst_n(rst_n), .raw_mode(cfg_q.code == 3'd0), .stb(stb),
    .ev(ev_vec), .act(act), .pend_flat(pend_flat)
  );

  always_comb begin
    tx_n  = cfg_q.tx_mode  ? (link_up && !(act[0] || act[1])) : act[0];
    rx_n  = cfg_q.rx_mode  ? (link_up && !act[1])             : act[1];
    dup_n = cfg_q.dup_mode ? full_dup                         : (full_dup || act[2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {led_link, led_dup, led_rx, led_tx} <= 4'b0;
    end else begin
      led_link <= !cfg_q.dis && link_up;
      led_dup  <= !cfg_q.dis && dup_n;
      led_rx   <= !cfg_q.dis && rx_n;
      led_tx   <= !cfg_q.dis && tx_n;
    end
  end
endmodule

// File: rtl/led_stretch_chk.sv
module led_stretch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [15:0] cfg_word,
  input logic        ms_tick,
  input logic        stb,
  input logic [2:0]  ev,
  input logic [5:0]  pend,
  input logic        link_up,
  input logic [3:0]  leds
);
  wire dis = cfg_word[15];
  wire [2:0] code = cfg_word[14:12];

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_word)); // R1

  AST_DISABLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> leds == 4'b0); // R2

  AST_STB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> ms_tick); // R4

  AST_REARM_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[0] && code != 3'd0) |=> pend[1:0] == 2'd2); // R10

  AST_REARM_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[2] && code != 3'd0) |=> pend[5:4] == 2'd2); // R10

  AST_DECAY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 3'd0 && !ev[1] && stb && pend[3:2] != 2'd0) |=> pend[3:2] == $past(pend[3:2]) - 2'd1); // R10

  AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> leds[3] == $past(link_up && !dis)); // R9
endmodule

bind led_stretch_ctrl led_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_q),
  .ms_tick(ms_tick), .stb(stb), .ev(ev_vec), .pend(pend_flat),
  .link_up(link_up), .leds({led_link, led_dup, led_rx, led_tx})
);

// File: tb/tb_led_stretch_ctrl.sv
module tb_led_stretch_ctrl;
  localparam int TICK = 2;
  localparam int BASE = 21;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [15:0] cfg_wdata = '0;
  logic ev_tx = 0, ev_rx = 0, ev_col = 0, link_up = 0, full_dup = 0;
  logic led_link, led_dup, led_rx, led_tx;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  led_stretch_ctrl #(.TICK_CYCLES(TICK), .BASE_MS(BASE)) dut (.*);

  function automatic int per_cycles(int c);
    return BASE * (1 << (c - 1)) * TICK;
  endfunction

  function automatic logic [15:0] word(bit dis, int code, bit dm, bit rm, bit tm);
    return {dis, code[2:0], 9'b0, dm, rm, tm};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // one-cycle pulse; returns at the negedge just after the event was clocked
  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) ev_tx = 1; else if (which == 1) ev_rx = 1; else ev_col = 1;
    @(negedge clk); ev_tx = 0; ev_rx = 0; ev_col = 0;
  endtask

  task automatic count_high(int which, int limit, output int n);
    logic v;
    n = 0;
    forever begin
      v = (which == 0) ? led_tx : (which == 1) ? led_rx : led_dup;
      if (!v || n >= limit) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk);
    chk({led_link, led_dup, led_rx, led_tx} == 4'b0, "R1 reset leds", {led_link, led_dup, led_rx, led_tx}, 0);
    pulse(0);
    count_high(0, 10000, n);
    chk(n >= per_cycles(2) && n <= 2*per_cycles(2)+2, "R1 default code 010 on-time", n, per_cycles(2));
  endtask

  task automatic t_raw();
    int n;
    wr(word(0, 0, 0, 0, 0));
    pulse(0);
    count_high(0, 100, n);
    chk(n == 1, "R3 raw pulse width", n, 1);
  endtask

  task automatic t_codes();
    for (int c = 1; c <= 7; c++) begin
      int n;
      wr(word(0, c, 0, 0, 0));
      pulse(1);
      count_high(1, 20000, n);
      chk(n >= per_cycles(c) && n <= 2*per_cycles(c)+2, $sformatf("R4 code %0d on-time", c), n, per_cycles(c));
    end
  endtask

  task automatic t_rearm();
    int dark = 0, n;
    wr(word(0, 1, 0, 0, 0));
    pulse(0);
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 30; j++) begin
        if (!led_tx) dark++;
        @(negedge clk);
      end
      ev_tx = 1; @(negedge clk); ev_tx = 0;
    end
    chk(dark == 0, "R5 continuous activity dark cycles", dark, 0);
    count_high(0, 1000, n);
    chk(n >= per_cycles(1) - 1, "R10 re-armed tail length", n, per_cycles(1));
  endtask

  task automatic t_tx_mode();
    int n;
    wr(word(0, 1, 0, 0, 0));
    pulse(1);
    chk(led_tx == 0, "R6 rx event ignored by tx led in mode 0", led_tx, 0);
    repeat (3*per_cycles(1)) @(negedge clk);
    link_up = 1;
    wr(word(0, 1, 0, 0, 1));
    @(negedge clk);
    chk(led_tx == 1, "R6 combined mode idle link lit", led_tx, 1);
    pulse(1);
    chk(led_tx == 0, "R6 combined mode dark on rx activity", led_tx, 0);
    n = 0;
    while (!led_tx && n < 10000) begin n++; @(negedge clk); end
    chk(n >= per_cycles(1) - 1 && n <= 2*per_cycles(1)+2, "R6 dark interval length", n, per_cycles(1));
    link_up = 0; @(negedge clk); @(negedge clk);
    chk(led_tx == 0, "R6 dark while link down", led_tx, 0);
  endtask

  task automatic t_rx_mode();
    link_up = 1;
    wr(word(0, 1, 0, 1, 0));
    @(negedge clk);
    chk(led_rx == 1, "R7 combined rx idle lit", led_rx, 1);
    pulse(1);
    chk(led_rx == 0, "R7 combined rx dark on event", led_rx, 0);
    link_up = 0;
    repeat (3*per_cycles(1)) @(negedge clk);
    chk(led_rx == 0, "R7 rx dark while link down", led_rx, 0);
  endtask

  task automatic t_dup_mode();
    full_dup = 0;
    wr(word(0, 1, 0, 0, 0));
    pulse(2);
    chk(led_dup == 1, "R8 collision lights dup led in mode 0", led_dup, 1);
    repeat (3*per_cycles(1)) @(negedge clk);
    chk(led_dup == 0, "R8 collision blink ends", led_dup, 0);
    wr(word(0, 1, 1, 0, 0));
    pulse(2);
    chk(led_dup == 0, "R8 collision ignored in mode 1", led_dup, 0);
    full_dup = 1; @(negedge clk); @(negedge clk);
    chk(led_dup == 1, "R8 full duplex lit in mode 1", led_dup, 1);
  endtask

  task automatic t_link_disable();
    link_up = 1; @(negedge clk);
    chk(led_link == 1, "R9 link led follows", led_link, 1);
    link_up = 0; @(negedge clk);
    chk(led_link == 0, "R9 link led off", led_link, 0);
    link_up = 1; full_dup = 1;
    wr(word(1, 1, 0, 1, 1));
    ev_tx = 1; @(negedge clk); ev_tx = 0;
    chk({led_link, led_dup, led_rx, led_tx} == 4'b0, "R2 disable forces dark", {led_link, led_dup, led_rx, led_tx}, 0);
    wr(word(0, 1, 0, 1, 1));
    @(negedge clk);
    chk(led_link == 1, "R2 re-enable restores link led", led_link, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_raw();
    t_codes();
    t_rearm();
    t_tx_mode();
    t_rx_mode();
    t_dup_mode();
    t_link_disable();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule